// File: doc/BRIEF.md
# Two-Lamp Sequencer with Latched Run Control

This block is a small hardware version of a relay-style lamp sequencer. A latched run flag is set by a Start button and cleared by a Stop button. While it is set, two chained retentive interval timers move the outputs through a repeating pattern: lamp A is lit during the first interval and lamp B during the second. When the second interval completes, both timers are cleared and the pattern starts again with lamp A.

Stop acts as a pause, not a restart. Dropping the run flag turns both lamps off, but the timers keep their accumulated counts. A later Start therefore picks up the pattern exactly where it stopped.

Time advances only on cycles where the tick strobe is high. The strobe comes from a time-base divider outside the block, and one strobe equals one time unit. The run flag and the lamps are combinational functions of the buttons and the registered state. As a result, they respond in the same cycle the buttons change, and the timer counts update at the next clock edge.

Top module: `lamp_sequencer`

## Requirements
- R1: The run output is high exactly when (start is high or the run state latched at the previous edge is high) and stop is low. If start and stop are both high, stop wins and the run output is low.
- R2: After start is released, the run output stays high on following cycles until stop is raised.
- R3: lamp_a_o is high exactly when the run output is high and acc_a_o is below PRESET_A.
- R4: lamp_b_o is high exactly when the run output is high, acc_a_o equals PRESET_A, and acc_b_o is below PRESET_B.
- R5: On each edge where tick is high, the run output is high and acc_a_o is below PRESET_A, acc_a_o increases by one. It never exceeds PRESET_A.
- R6: acc_b_o increases by one on an edge only when tick is high, the run output is high, acc_a_o equals PRESET_A and acc_b_o is below PRESET_B.
- R7: In a cycle where the run output is high and both counts sit at their presets, both lamps are low. Both counts become zero at the next edge, whether or not tick is high.
- R8: While the run output is low, both counts keep their values, and a later start continues the pattern from those values.
- R9: A synchronous reset clears the latched run state and both counts. With the buttons released after reset, all outputs are zero.
- R10: When tick is low (strobe mode), neither count changes unless it is being cleared under R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Time-base strobe, one time unit per high cycle |
| start_i | input | 1 | Start button level |
| stop_i | input | 1 | Stop button level, dominant |
| run_o | output | 1 | Latched run flag |
| lamp_a_o | output | 1 | First lamp |
| lamp_b_o | output | 1 | Second lamp |
| acc_a_o | output | ACC_W | First timer count |
| acc_b_o | output | ACC_W | Second timer count |

## Verification
A single run through a vector table drives the sequencer through complete lamp A, lamp B, lamp A rounds.

Cycles with tick held low are interleaved with ticking cycles. This separates time-based advance from advance on every clock. It also shows that the clear at the end of a round is independent of the tick.

Stop is pulsed separately during the lamp A phase and during the lamp B phase, and the pattern is then resumed. This distinguishes a pause from a restart. One cycle raises start and stop together to confirm that stop dominates. A reset applied while running, with start and tick both high, confirms that reset overrides the other inputs.

// File: rtl/lseq_pkg.sv
package lseq_pkg;

   // Selects how the timers advance: on a strobe, or on every clock.
   typedef enum logic {
      TICK_FREE   = 1'b0,
      TICK_STROBE = 1'b1
   } tick_mode_e;

   // A stage lamp is lit while the run flag is up, the previous stage has
   // finished, and this stage has not.
   function automatic logic stage_lit(input logic run, input logic prev_done,
                                      input logic own_done);
      return run & prev_done & ~own_done;
   endfunction

endpackage

// File: rtl/lseq_latch.sv
module lseq_latch (
   input  logic clk_i,
   input  logic rst_i,
   input  logic start_i,
   input  logic stop_i,
   output logic run_o
);

   logic held_q;

   // Seal-in path: the stored run state is fed back through one register.
   assign run_o = (start_i | held_q) & ~stop_i;

   always_ff @(posedge clk_i) begin
      if (rst_i) held_q <= 1'b0;
      else       held_q <= run_o;
   end

   AST_RUN_SEALS: assert property (@(posedge clk_i) disable iff (rst_i)
      (run_o && !stop_i) |=> (run_o || stop_i)) else $error("seal-in lost"); // R2

   AST_RESET_DROPS: assert property (@(posedge clk_i)
      rst_i |=> (held_q == 1'b0)) else $error("latch not cleared"); // R9

endmodule

// File: rtl/lseq_rto.sv
module lseq_rto #(
   parameter int                  ACC_W     = 8,
   parameter int                  PRESET    = 5,
   parameter lseq_pkg::tick_mode_e TICK_MODE = lseq_pkg::TICK_STROBE
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             tick_i,
   input  logic             en_i,
   input  logic             clr_i,
   output logic [ACC_W-1:0] acc_o,
   output logic             reached_o
);

   localparam logic [ACC_W-1:0] PRE_V = ACC_W'(PRESET);
   localparam logic [ACC_W-1:0] ONE_V = ACC_W'(1);

   logic [ACC_W-1:0] acc_q;
   logic             step_ok;
   logic             advance;

   // Choose the time base.
   generate
      if (TICK_MODE == lseq_pkg::TICK_STROBE) begin : g_strobe
         assign step_ok = tick_i;
      end else begin : g_free
         logic unused_tick;
         assign unused_tick = tick_i;
         assign step_ok     = 1'b1;
      end
   endgenerate

   // The count saturates at the preset and is held when disabled.
   assign reached_o = (acc_q >= PRE_V);
   assign advance   = en_i & step_ok & ~reached_o;
   assign acc_o     = acc_q;

   always_ff @(posedge clk_i) begin
      if (rst_i || clr_i) acc_q <= '0;
      else if (advance)   acc_q <= acc_q + ONE_V;
   end

   AST_ACC_CAPPED: assert property (@(posedge clk_i) disable iff (rst_i)
      acc_q <= PRE_V) else $error("count above preset"); // R5

   AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i && step_ok && !clr_i && acc_q < PRE_V) |=> (acc_q == $past(acc_q) + ONE_V))
      else $error("count did not step"); // R5

   AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
      (!en_i && !clr_i) |=> $stable(acc_q)) else $error("idle count moved"); // R8

   AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (rst_i)
      clr_i |=> (acc_q == '0)) else $error("clear ignored"); // R7

   AST_RESET_ZERO: assert property (@(posedge clk_i)
      rst_i |=> (acc_q == '0)) else $error("reset ignored"); // R9

   generate
      if (TICK_MODE == lseq_pkg::TICK_STROBE) begin : g_tick_chk
         AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
            (!tick_i && !clr_i) |=> $stable(acc_q)) else $error("moved without tick"); // R10
      end
   endgenerate

endmodule

// File: rtl/lseq_lamps.sv
module lseq_lamps #(
   parameter int STAGES = 2
) (
   input  logic              run_i,
   input  logic [STAGES-1:0] done_i,
   output logic [STAGES-1:0] lamp_o
);

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_lamp
         if (s == 0) begin : g_first
            assign lamp_o[s] = lseq_pkg::stage_lit(run_i, 1'b1, done_i[s]);
         end else begin : g_next
            assign lamp_o[s] = lseq_pkg::stage_lit(run_i, done_i[s-1], done_i[s]);
         end
      end
   endgenerate

   always_comb begin
      AST_ONE_LAMP: assert ($onehot0(lamp_o)) else $error("two lamps lit"); // R3
   end

endmodule

// File: rtl/lamp_sequencer.sv
module lamp_sequencer #(
   parameter int                   ACC_W     = 8,
   parameter int                   PRESET_A  = 5,
   parameter int                   PRESET_B  = 5,
   parameter lseq_pkg::tick_mode_e TICK_MODE = lseq_pkg::TICK_STROBE
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             tick_i,
   input  logic             start_i,
   input  logic             stop_i,
   output logic             run_o,
   output logic             lamp_a_o,
   output logic             lamp_b_o,
   output logic [ACC_W-1:0] acc_a_o,
   output logic [ACC_W-1:0] acc_b_o
);

   localparam int STAGES  = 2;
   localparam int LAST    = STAGES - 1;
   localparam int ACC_MAX = (1 << ACC_W) - 1;
   localparam int PRESETS [STAGES] = '{PRESET_A, PRESET_B};

   // Elaboration-time parameter checks.
   generate
      if (ACC_W < 1 || ACC_W > 16) begin : g_bad_width
         $error("ACC_W must be 1..16");
      end
      if (PRESET_A < 1 || PRESET_A > ACC_MAX) begin : g_bad_pa
         $error("PRESET_A does not fit ACC_W");
      end
      if (PRESET_B < 1 || PRESET_B > ACC_MAX) begin : g_bad_pb
         $error("PRESET_B does not fit ACC_W");
      end
   endgenerate

   logic                          run;
   logic [STAGES-1:0]             enable;
   logic [STAGES-1:0]             reached;
   logic [STAGES-1:0]             done;
   logic [STAGES-1:0]             lamp;
   logic [STAGES-1:0][ACC_W-1:0]  acc;
   logic                          round_end;

   lseq_latch u_latch (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .start_i (start_i),
      .stop_i  (stop_i),
      .run_o   (run)
   );

   // Timer chain: each stage is enabled by the completion of the one before,
   // and the completion of the last stage clears every stage.
   assign round_end = done[LAST];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_head
            assign enable[s] = run;
         end else begin : g_tail
            assign enable[s] = done[s-1];
         end
         assign done[s] = enable[s] & reached[s];

         lseq_rto #(
            .ACC_W     (ACC_W),
            .PRESET    (PRESETS[s]),
            .TICK_MODE (TICK_MODE)
         ) u_rto (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .tick_i    (tick_i),
            .en_i      (enable[s]),
            .clr_i     (round_end),
            .acc_o     (acc[s]),
            .reached_o (reached[s])
         );
      end
   endgenerate

   lseq_lamps #(.STAGES(STAGES)) u_lamps (
      .run_i  (run),
      .done_i (done),
      .lamp_o (lamp)
   );

   assign run_o    = run;
   assign lamp_a_o = lamp[0];
   assign lamp_b_o = lamp[1];
   assign acc_a_o  = acc[0];
   assign acc_b_o  = acc[1];

   AST_STOP_DARK: assert property (@(posedge clk_i) disable iff (rst_i)
      stop_i |-> (!run_o && !lamp_a_o && !lamp_b_o)) else $error("stop not dominant"); // R1

   AST_ROUND_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
      (run_o && acc_a_o == ACC_W'(PRESET_A) && acc_b_o == ACC_W'(PRESET_B))
      |=> (acc_a_o == '0 && acc_b_o == '0)) else $error("round did not wrap"); // R7

   AST_B_WAITS_A: assert property (@(posedge clk_i) disable iff (rst_i)
      (acc_a_o != ACC_W'(PRESET_A)) |=> $stable(acc_b_o) || acc_b_o == '0)
      else $error("second timer ran early"); // R6

endmodule

// File: tb/lamp_sequencer_tb_top.sv
`timescale 1ns/1ps
module lamp_sequencer_tb_top;

   localparam int ACC_W = 4;
   localparam int PA    = 3;
   localparam int PB    = 2;
   localparam int ROWS  = 20;

   logic             clk = 1'b0;
   logic             rst, tick, start, stop;
   logic             run, lamp_a, lamp_b;
   logic [ACC_W-1:0] acc_a, acc_b;

   int checks = 0;
   int fails  = 0;
   bit done_flag = 1'b0;

   always #2.5 clk = ~clk;

   lamp_sequencer #(
      .ACC_W    (ACC_W),
      .PRESET_A (PA),
      .PRESET_B (PB)
   ) dut_i (
      .clk_i    (clk),
      .rst_i    (rst),
      .tick_i   (tick),
      .start_i  (start),
      .stop_i   (stop),
      .run_o    (run),
      .lamp_a_o (lamp_a),
      .lamp_b_o (lamp_b),
      .acc_a_o  (acc_a),
      .acc_b_o  (acc_b)
   );

   // Row layout: {tick, start, stop, run, lamp_a, lamp_b, acc_a[3:0], acc_b[3:0]}
   // Expected values describe the cycle in which the inputs are applied,
   // before the next edge; counts shown are the state entering that edge.
   localparam logic [13:0] VEC [ROWS] = '{
      {3'b100, 3'b000, 4'd0, 4'd0},  //  0 idle ticking, nothing moves   R8
      {3'b010, 3'b110, 4'd0, 4'd0},  //  1 start, no tick                 R10
      {3'b100, 3'b110, 4'd0, 4'd0},  //  2 sealed in, count A             R5
      {3'b100, 3'b110, 4'd1, 4'd0},  //  3                                R5
      {3'b000, 3'b110, 4'd2, 4'd0},  //  4 no tick, hold                  R10
      {3'b100, 3'b110, 4'd2, 4'd0},  //  5                                R5
      {3'b100, 3'b101, 4'd3, 4'd0},  //  6 A done, lamp B, count B        R6
      {3'b100, 3'b101, 4'd3, 4'd1},  //  7                                R6
      {3'b000, 3'b100, 4'd3, 4'd2},  //  8 round end, clear w/o tick      R7
      {3'b100, 3'b110, 4'd0, 4'd0},  //  9 lamp A again                   R5
      {3'b101, 3'b000, 4'd1, 4'd0},  // 10 stop pauses                    R1
      {3'b100, 3'b000, 4'd1, 4'd0},  // 11 stays off after stop release   R8
      {3'b110, 3'b110, 4'd1, 4'd0},  // 12 resume from 1                  R2
      {3'b111, 3'b000, 4'd2, 4'd0},  // 13 both buttons: stop wins        R1
      {3'b110, 3'b110, 4'd2, 4'd0},  // 14                                R8
      {3'b100, 3'b101, 4'd3, 4'd0},  // 15 lamp B phase                   R4
      {3'b101, 3'b000, 4'd3, 4'd1},  // 16 pause during lamp B            R8
      {3'b110, 3'b101, 4'd3, 4'd1},  // 17 resume in lamp B               R8
      {3'b100, 3'b100, 4'd3, 4'd2},  // 18 round end                      R7
      {3'b100, 3'b110, 4'd0, 4'd0}   // 19 restarted with lamp A          R3
   };

   function automatic string row_tag(input int r);
      case (r)
         0, 11, 14, 16, 17: return "R8";
         1, 4:              return "R10";
         6, 7:              return "R6";
         8, 18:             return "R7";
         10, 13:            return "R1";
         12:                return "R2";
         15:                return "R4";
         19:                return "R3";
         default:           return "R5";
      endcase
   endfunction

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic check_all(input string tag, input logic [13:0] v);
      check(tag, "run",    int'(run),    int'(v[10]));
      check(tag, "lamp_a", int'(lamp_a), int'(v[9]));
      check(tag, "lamp_b", int'(lamp_b), int'(v[8]));
      check(tag, "acc_a",  int'(acc_a),  int'(v[7:4]));
      check(tag, "acc_b",  int'(acc_b),  int'(v[3:0]));
   endtask

   initial begin
      rst = 1'b1; tick = 1'b0; start = 1'b0; stop = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      check_all("R9", 14'b000_000_0000_0000);

      for (int r = 0; r < ROWS; r++) begin
         @(negedge clk);
         {tick, start, stop} = VEC[r][13:11];
         #1;
         check_all(row_tag(r), VEC[r]);
      end

      // Reset while running with start and tick held: R9.
      @(negedge clk);
      rst = 1'b1; tick = 1'b1; start = 1'b1; stop = 1'b0;
      @(negedge clk);
      rst = 1'b0; tick = 1'b0; start = 1'b0;
      #1;
      check_all("R9", 14'b000_000_0000_0000);

      // Idle after reset with ticks: latch must stay clear (R2 needs start).
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      #1;
      check_all("R8", 14'b100_000_0000_0000);

      done_flag = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule